// File: doc/BRIEF.md
# Compressed Bus Word Decoder

This block turns a stream of printable characters into 32-bit read-response words. Each accepted character becomes a 6-bit symbol. A word starts with a header symbol. The header either opens a full raw word or points back into a history of words decoded earlier, so a word that has already been sent can be resent with one or two characters instead of six.

Raw words are appended to a 1024-entry circular history. The other header kinds read from that history, counting back from the next write slot: a repeat of the newest entry, a short lookback of 2 to 9 entries, and a long lookback of up to 521 entries. Lookups never change the history. Every decoded word carries an address-increment flag taken from bit 0 of its header symbol.

Top module: `bus_word_decoder`

## Requirements
- R1: Digits '0'..'9' map to symbols 0..9, and upper-case 'A'..'Z' map to symbols 10..35.
- R2: Lower-case 'a'..'z' map to symbols 36..61. '@' maps to 62 and '%' maps to 63.
- R3: Any other character is ignored. It produces no output and does not disturb a word that is partly received.
- R4: A header whose bits [5:3] are 111 opens a raw word. Header bits [1:0] become word bits [31:30]. Five further symbols supply word bits [29:24], [23:18], [17:12], [11:6] and [5:0], in that order.
- R5: Each raw word is stored at the write slot, and the slot then advances by one. The slot wraps modulo 1024.
- R6: A header of 000110 or 000111 outputs the entry one before the write slot.
- R7: A header whose bits [5:4] are 10 outputs the entry (header bits [3:1] + 2) before the write slot.
- R8: A header whose bits [5:4] are 01 takes one more symbol x. It outputs the entry D before the write slot, where D = 10 + header bits [3:1] × 64 + x, limited to 521.
- R9: The address-increment output equals bit 0 of the header symbol, for every kind of word.
- R10: Repeats and lookbacks do not write the history and do not move the write slot.
- R11: A header that matches none of the patterns above is discarded without output. The next symbol is then treated as a header.
- R12: Synchronous reset sets the write slot to 0, drops any partial word and clears the output-valid flag. History contents survive reset.
- R13: The output-valid flag is high for exactly one cycle, in the cycle after the clock edge that accepts a word's final character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A character is presented |
| in_ready | output | 1 | A character is accepted when high (always high) |
| in_char | input | 8 | Character code |
| out_valid | output | 1 | One-cycle strobe: a decoded word is present |
| out_word | output | 32 | Decoded word |
| out_inc | output | 1 | Address-increment flag of the decoded word |

## Verification
The assertions assume that reset is applied before the first character. They also assume that a header is the only way to start a word, so a change in the write slot can only come from a completed raw word. They do not check that a lookback points at an entry that has actually been written. The stimulus takes care of that: it tracks how many raw words have been sent and issues a repeat or lookback only when its distance is within that count. Random headers, junk characters and resets mid-word are drawn from a fixed-seed generator, so every run sends the same stream.

// File: rtl/bus_word_decoder.sv
module bus_word_decoder #(
  parameter int AW       = 10,
  parameter int LONG_MAX = 521
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_char,
  output logic        out_valid,
  output logic [31:0] out_word,
  output logic        out_inc
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [1:0] {S_HEAD, S_RAW, S_LONG} st_t;

  st_t            st;
  logic [31:0]    hist [DEPTH];
  logic [AW-1:0]  wp;
  logic [31:0]    acc;
  logic [2:0]     cnt;
  logic           inc_q;
  logic [5:0]     sym;
  logic           sym_ok;
  logic           take;
  logic [9:0]     lsum, loff;
  logic [AW-1:0]  rd_idx;
  logic [31:0]    raw_word;
  logic           wr_en;

  always_comb begin
    sym_ok = 1'b1;
    sym    = '0;
    if (in_char >= 8'h30 && in_char <= 8'h39)      sym = 6'(in_char - 8'h30);
    else if (in_char >= 8'h41 && in_char <= 8'h5A) sym = 6'(in_char - 8'h37);
    else if (in_char >= 8'h61 && in_char <= 8'h7A) sym = 6'(in_char - 8'h3D);
    else if (in_char == 8'h40)                     sym = 6'd62;
    else if (in_char == 8'h25)                     sym = 6'd63;
    else                                           sym_ok = 1'b0;
  end

  assign in_ready = 1'b1;
  assign take     = in_valid && sym_ok;
  assign raw_word = {acc[25:0], sym};
  assign wr_en    = take && st == S_RAW && cnt == 3'd4;
  assign lsum     = 10'd10 + {1'b0, acc[2:0], sym};
  assign loff     = (lsum > 10'(LONG_MAX)) ? 10'(LONG_MAX) : lsum;

  always_comb begin
    if (st == S_LONG)           rd_idx = wp - AW'(loff);
    else if (sym[5:4] == 2'b10) rd_idx = wp - (AW'(sym[3:1]) + AW'(2));
    else                        rd_idx = wp - AW'(1);
  end

  always_ff @(posedge clk)
    if (wr_en) hist[wp] <= raw_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_HEAD;
      wp        <= '0;
      acc       <= '0;
      cnt       <= '0;
      inc_q     <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      out_inc   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        case (st)
          S_HEAD: begin
            inc_q <= sym[0];
            if (sym[5:3] == 3'b111) begin
              st  <= S_RAW;
              acc <= {30'd0, sym[1:0]};
              cnt <= '0;
            end else if (sym[5:4] == 2'b01) begin
              st  <= S_LONG;
              acc <= {29'd0, sym[3:1]};
            end else if (sym[5:4] == 2'b10 || sym[5:1] == 5'b00011) begin
              out_valid <= 1'b1;
              out_word  <= hist[rd_idx];
              out_inc   <= sym[0];
            end
          end
          S_RAW: begin
            acc <= raw_word;
            cnt <= cnt + 3'd1;
            if (cnt == 3'd4) begin
              out_valid <= 1'b1;
              out_word  <= raw_word;
              out_inc   <= inc_q;
              wp        <= wp + AW'(1);
              st        <= S_HEAD;
            end
          end
          S_LONG: begin
            out_valid <= 1'b1;
            out_word  <= hist[rd_idx];
            out_inc   <= inc_q;
            st        <= S_HEAD;
          end
          default: st <= S_HEAD;
        endcase
      end
    end
  end

  // R13
  out_src_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && sym_ok));

  // R5
  wp_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wp != $past(wp)) |-> (out_valid && wp == $past(wp) + AW'(1)));

  // R10
  lookup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && out_valid && $past(st) != S_RAW) |-> wp == $past(wp));

  // R11
  drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(take) && $past(st) == S_HEAD && $past(sym[5:3]) == 3'b110)
      |-> (!out_valid && st == S_HEAD));
endmodule

// File: tb/tb_bus_word_decoder.sv
module tb_bus_word_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_char = 8'h00;
  logic        in_ready, out_valid, out_inc;
  logic [31:0] out_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] hist_m [1024];
  int wp_m   = 0;
  int filled = 0;

  always #10 clk = ~clk;

  bus_word_decoder dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .out_valid(out_valid), .out_word(out_word), .out_inc(out_inc)
  );

  function automatic logic [7:0] enc(input int s);
    if (s < 10)      return 8'(8'h30 + s);
    else if (s < 36) return 8'(8'h41 + s - 10);
    else if (s < 62) return 8'(8'h61 + s - 36);
    else if (s == 62) return 8'h40;
    else             return 8'h25;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] c);
    @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic none(input string tag);
    chk(out_valid == 1'b0, tag, 32'(out_valid), 32'd0);
  endtask

  task automatic got(input logic [31:0] w, input logic inc, input string tag);
    chk(out_valid == 1'b1, {tag, " valid"}, 32'(out_valid), 32'd1);
    chk(out_word == w, {tag, " word"}, out_word, w);
    chk(out_inc == inc, {tag, " inc R9"}, 32'(out_inc), 32'(inc));
    @(negedge clk);
    chk(out_valid == 1'b0, "R13 pulse", 32'(out_valid), 32'd0);
  endtask

  task automatic raw(input logic [31:0] w, input bit junk, input string tag);
    int s [6];
    s[0] = {3'b111, 1'($urandom % 2), w[31:30]};
    s[1] = w[29:24]; s[2] = w[23:18]; s[3] = w[17:12]; s[4] = w[11:6]; s[5] = w[5:0];
    for (int i = 0; i < 6; i++) begin
      if (junk && i == 2) begin
        put(8'h21);
        none("R3 junk mid-word");
      end
      put(enc(s[i]));
      if (i < 5) none({tag, " partial"});
    end
    got(w, w[30], tag);
    hist_m[wp_m] = w;
    wp_m = (wp_m + 1) % 1024;
    if (filled < 1024) filled++;
  endtask

  task automatic rep(input bit inc);
    put(enc({5'b00011, inc}));
    got(hist_m[(wp_m + 1023) % 1024], inc, "R6 repeat");
  endtask

  task automatic shortlb(input int k, input bit inc);
    put(enc({2'b10, 3'(k), inc}));
    got(hist_m[(wp_m + 1024 - (k + 2)) % 1024], inc, "R7 short");
  endtask

  task automatic longlb(input int h, input int x, input bit inc);
    int off;
    put(enc({2'b01, 3'(h), inc}));
    none("R8 long header");
    put(enc(x));
    off = 10 + h * 64 + x;
    if (off > 521) off = 521;
    got(hist_m[(wp_m + 1024 - off) % 1024], inc, "R8 long");
  endtask

  task automatic badhead(input int s);
    put(enc(s));
    none("R11 bad header");
    @(negedge clk);
    none("R11 bad header later");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R13 watchdog act %0d exp %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) hist_m[i] = '0;
    repeat (3) @(negedge clk);
    none("R12 reset output");
    rst = 1'b0;
    @(negedge clk);
    none("R12 idle after reset");

    raw(32'h0000_0000, 1'b0, "R1 digits");
    raw({2'b01, 6'd9, 6'd1, 6'd10, 6'd35, 6'd5}, 1'b0, "R1 upper");
    raw({2'b10, 6'd62, 6'd35, 6'd10, 6'd61, 6'd36}, 1'b0, "R2 lower");
    raw(32'hFFFF_FFFF, 1'b0, "R2 percent");
    raw(32'h1234_5678, 1'b1, "R3 junk");
    put(8'h20); none("R3 space");
    put(8'h7E); none("R3 tilde");
    raw(32'hCAFE_F00D, 1'b0, "R4 after junk");
    rep(1'b0);
    rep(1'b1);
    for (int i = 0; i < 6; i++) raw($urandom, 1'b0, "R4 fill");
    for (int k = 0; k < 8; k++) shortlb(k, 1'(k));
    rep(1'b0);
    foreach (hist_m[i]) ; 
    badhead(0); badhead(5); badhead(8); badhead(15); badhead(48); badhead(55);
    raw(32'h8000_0001, 1'b0, "R11 recover");
    shortlb(0, 1'b1);
    rep(1'b1);

    for (int n = 0; n < 2600; n++) begin
      int op;
      op = int'($urandom % 8);
      if (op == 4 && filled >= 1) rep(1'($urandom));
      else if (op == 5 && filled >= 9) shortlb(int'($urandom % 8), 1'($urandom));
      else if (op == 6 && filled >= 521) longlb(int'($urandom % 8), int'($urandom % 64), 1'($urandom));
      else if (op == 7) badhead((($urandom % 2) == 0) ? int'($urandom % 6) : 48 + int'($urandom % 8));
      else raw($urandom, ($urandom % 8) == 0, "R5 random raw");
    end
    longlb(7, 63, 1'b1);
    longlb(0, 0, 1'b0);
    rep(1'b0);

    put(enc(60));
    put(enc(3));
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    none("R12 reset mid-word");
    wp_m = 0;
    raw(32'hA5A5_5A5A, 1'b0, "R12 first after reset");
    longlb(0, 0, 1'b0);
    shortlb(7, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule